// File: doc/BRIEF.md
# EEPROM Status and Write-Protect Controller

This block is the command-admission logic on the slave side of a serial EEPROM. A bus front end decodes each instruction and raises one command strobe for one clock. The block answers a cycle later with an acknowledge or a missing acknowledge. Its decision uses the status register it owns: a write-enable latch, a two-bit block-protect field and a read-only write-in-progress flag. The target address of a data write is checked against the protected region chosen by the block-protect field.

An accepted write-type command starts an internal write cycle. The block reports this with a start strobe and an operation code for the array sequencer. It then counts timebase ticks until the cycle ends: a normal count for byte/page writes and status writes, and a longer count for fill-all-ones and fill-all-zeros. At the end of the cycle it pulses a done strobe and clears the busy flag and the write-enable latch. A status write also loads the new protect bits at that point. While the cycle runs, only a status read is answered.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: `status` is {3'b000, protect[1:0] in bits 4:3, bit 2 = 0, write-enable latch in bit 1, write-in-progress in bit 0}.
- R2: After reset `status` is 8'h00 and `ack`, `nack`, `wr_start`, `wr_done` are 0.
- R3: While idle, `cmd_wren` sets the latch and `cmd_wrdi` clears it. Both are acknowledged on `ack` in the cycle after the strobe, and the new latch value shows in `status` in that same cycle.
- R4: Protect code 00 protects nothing, 01 protects addresses at or above 3/4 of the array, 10 protects addresses at or above 1/2, and 11 protects all addresses. An idle `cmd_write` is accepted only when the latch is 1 and the address is unprotected. Otherwise it gets `nack` and the latch stays set.
- R5: An idle `cmd_wrsr` is accepted only when the latch is 1. Otherwise it gets `nack` and the status is unchanged.
- R6: An idle `cmd_setal` or `cmd_eral` is accepted only when the latch is 1 and protect is 00. Otherwise it gets `nack` and the latch stays as it was.
- R7: An accepted write-type command raises `ack` and `wr_start` together in the cycle after the strobe, with `wr_op` set to 0 for write, 1 for status write, 2 for fill-ones and 3 for fill-zeros. Bit 0 of `status` is 1 in that cycle.
- R8: The cycle ends on the NORM_TICKS-th sampled `tick` after the start (LONG_TICKS for fill commands). One cycle after that tick, `wr_done` pulses, bits 0 and 1 of `status` read 0, and after a status write bits 4:3 hold bits 4:3 of the `wrsr_data` that was captured.
- R9: While a cycle runs, `cmd_rdsr` gets `ack` and every other strobe gets `nack` without changing the status.
- R10: While idle, `cmd_rdsr`, `cmd_read` and `cmd_crrd` always get `ack` and do not change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Write-cycle timebase pulse |
| cmd_wren | input | 1 | Enable-writes strobe |
| cmd_wrdi | input | 1 | Disable-writes strobe |
| cmd_rdsr | input | 1 | Status-read strobe |
| cmd_read | input | 1 | Array read strobe |
| cmd_crrd | input | 1 | Current-address read strobe |
| cmd_write | input | 1 | Array write strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_setal | input | 1 | Fill-all-ones strobe |
| cmd_eral | input | 1 | Fill-all-zeros strobe |
| addr | input | AW | Target address of an array write |
| wrsr_data | input | 8 | Data for a status write |
| ack | output | 1 | Command accepted |
| nack | output | 1 | Command rejected |
| wr_start | output | 1 | Internal write cycle begins |
| wr_op | output | 2 | Kind of write started |
| wr_done | output | 1 | Internal write cycle ended |
| status | output | 8 | Status byte |

## Verification
Every result has one register between the strobe and the output. Acknowledges, start strobes, operation codes and latch changes are due in the cycle after the strobe. The end of a write cycle is due one cycle after the final counted tick. The bench drives inputs on the falling edge and advances a cycle-level model at each step. At the next falling edge it compares every output with the model's prediction, so each check samples exactly the cycle in which the result is due. Directed sequences reach each protect setting, rejected fills and commands sent while busy. Random traffic with random tick gaps then covers the rest.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_STATUS = 2'd1,
    OP_FILL1  = 2'd2,
    OP_FILL0  = 2'd3
  } wr_op_e;

  localparam int WEL_BIT = 1;
  localparam int WIP_BIT = 0;
  localparam int BP_LSB  = 3;
endpackage

// File: rtl/eewp_prot_check.sv
module eewp_prot_check #(
  parameter int AW = 10
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          prot
);
  logic top_quarter;
  logic top_half;

  assign top_half    = addr[AW-1];
  assign top_quarter = addr[AW-1] & addr[AW-2];

  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = top_quarter;
      2'b10:   prot = top_half;
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/eewp_cycle_timer.sv
module eewp_cycle_timer #(
  parameter int NORM_TICKS = 50,
  parameter int LONG_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign done = busy_q & tick & (cnt_q == CW'(1));
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = long_sel ? CW'(LONG_TICKS) : CW'(NORM_TICKS);
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assert_cnt_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eewp_pkg::*;
#(
  parameter int AW         = 10,
  parameter int NORM_TICKS = 50,
  parameter int LONG_TICKS = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_rdsr,
  input  logic          cmd_read,
  input  logic          cmd_crrd,
  input  logic          cmd_write,
  input  logic          cmd_wrsr,
  input  logic          cmd_setal,
  input  logic          cmd_eral,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wrsr_data,
  output logic          ack,
  output logic          nack,
  output logic          wr_start,
  output logic [1:0]    wr_op,
  output logic          wr_done,
  output logic [7:0]    status
);
  logic       wel_q, wel_d;
  logic [1:0] bp_q, bp_d;
  logic [1:0] pend_q, pend_d;
  wr_op_e     op_q, op_d;
  logic       ack_q, nack_q, start_q, done_q;
  logic       acc_d, rej_d, start_d;
  logic       wip, done_d, prot, any_cmd;

  eewp_prot_check #(.AW(AW)) u_prot (
    .bp(bp_q), .addr(addr), .prot(prot)
  );

  eewp_cycle_timer #(.NORM_TICKS(NORM_TICKS), .LONG_TICKS(LONG_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_d),
    .long_sel(op_d == OP_FILL1 || op_d == OP_FILL0),
    .tick(tick), .busy(wip), .done(done_d)
  );

  assign any_cmd = cmd_wren | cmd_wrdi | cmd_rdsr | cmd_read | cmd_crrd |
                   cmd_write | cmd_wrsr | cmd_setal | cmd_eral;

  always_comb begin
    acc_d   = 1'b0;
    rej_d   = 1'b0;
    start_d = 1'b0;
    op_d    = op_q;
    wel_d   = wel_q;
    bp_d    = bp_q;
    pend_d  = pend_q;
    if (wip) begin
      if (cmd_rdsr)     acc_d = 1'b1;
      else if (any_cmd) rej_d = 1'b1;
    end else if (cmd_wren) begin
      acc_d = 1'b1;
      wel_d = 1'b1;
    end else if (cmd_wrdi) begin
      acc_d = 1'b1;
      wel_d = 1'b0;
    end else if (cmd_rdsr || cmd_read || cmd_crrd) begin
      acc_d = 1'b1;
    end else if (cmd_write) begin
      if (wel_q && !prot) begin
        acc_d = 1'b1; start_d = 1'b1; op_d = OP_WRITE;
      end else rej_d = 1'b1;
    end else if (cmd_wrsr) begin
      if (wel_q) begin
        acc_d = 1'b1; start_d = 1'b1; op_d = OP_STATUS;
        pend_d = wrsr_data[BP_LSB+1:BP_LSB];
      end else rej_d = 1'b1;
    end else if (cmd_setal || cmd_eral) begin
      if (wel_q && bp_q == 2'b00) begin
        acc_d = 1'b1; start_d = 1'b1;
        op_d  = cmd_setal ? OP_FILL1 : OP_FILL0;
      end else rej_d = 1'b1;
    end
    if (done_d) begin
      wel_d = 1'b0;
      if (op_q == OP_STATUS) bp_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      bp_q    <= 2'b00;
      pend_q  <= 2'b00;
      op_q    <= OP_WRITE;
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      wel_q   <= wel_d;
      bp_q    <= bp_d;
      pend_q  <= pend_d;
      op_q    <= op_d;
      ack_q   <= acc_d;
      nack_q  <= rej_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign ack      = ack_q;
  assign nack     = nack_q;
  assign wr_start = start_q;
  assign wr_op    = op_q;
  assign wr_done  = done_q;

  always_comb begin
    status          = 8'h00;
    status[WIP_BIT] = wip;
    status[WEL_BIT] = wel_q;
    status[BP_LSB+1:BP_LSB] = bp_q;
  end

  assert_ack_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && nack));
  assert_start_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (ack && status[WIP_BIT]));
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!status[WIP_BIT] && !status[WEL_BIT]));
  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && cmd_write) |=> (nack && !wr_start));
  assert_busy_rdsr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && cmd_rdsr) |=> ack);
  assert_fill_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_setal || cmd_eral) && bp_q != 2'b00) |=> !wr_start);
endmodule

// File: tb/sim_eeprom_wp_ctrl.sv
module sim_eeprom_wp_ctrl;
  localparam int AW = 8;
  localparam int NT = 6;
  localparam int LT = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [8:0] cmds = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ack, nack, wr_start, wr_done;
  logic [1:0] wr_op;
  logic [7:0] status;

  int checks = 0;
  int fails = 0;

  logic m_wel, m_wip;
  logic [1:0] m_bp, m_pend, m_op;
  int m_left;
  logic e_ack, e_nack, e_start, e_done;
  logic [1:0] e_op;
  string e_tag;

  always #2 clk = ~clk;

  eeprom_wp_ctrl #(.AW(AW), .NORM_TICKS(NT), .LONG_TICKS(LT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_wren(cmds[0]), .cmd_wrdi(cmds[1]), .cmd_rdsr(cmds[2]),
    .cmd_read(cmds[3]), .cmd_crrd(cmds[4]), .cmd_write(cmds[5]),
    .cmd_wrsr(cmds[6]), .cmd_setal(cmds[7]), .cmd_eral(cmds[8]),
    .addr(addr), .wrsr_data(wdata),
    .ack(ack), .nack(nack), .wr_start(wr_start), .wr_op(wr_op),
    .wr_done(wr_done), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic is_prot(input logic [1:0] bp, input int a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= (3 * DEPTH) / 4;
      2'b10:   return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {3'b000, m_bp, 1'b0, m_wel, m_wip};
  endfunction

  // c: 0 idle, 1 wren, 2 wrdi, 3 rdsr, 4 read, 5 crrd, 6 write, 7 wrsr, 8 setal, 9 eral
  task automatic cyc(input int c, input int a, input logic [7:0] d, input logic t);
    @(negedge clk);
    chk({"R1 status ", e_tag}, status, exp_status());
    chk({"ack ", e_tag}, ack, e_ack);
    chk({"nack ", e_tag}, nack, e_nack);
    chk("R7 wr_start", wr_start, e_start);
    if (e_start) chk("R7 wr_op", wr_op, e_op);
    chk("R8 wr_done", wr_done, e_done);
    cmds  = (c == 0) ? 9'd0 : 9'(1) << (c - 1);
    addr  = AW'(a);
    wdata = d;
    tick  = t;
    e_ack = 0; e_nack = 0; e_start = 0; e_done = 0; e_op = 2'd0; e_tag = "R1";
    if (m_wip) begin
      if (c != 0) e_tag = "R9";
      if (c == 3) e_ack = 1;
      else if (c != 0) e_nack = 1;
      if (t) begin
        m_left--;
        if (m_left == 0) begin
          m_wip = 0; m_wel = 0; e_done = 1;
          if (m_op == 2'd1) m_bp = m_pend;
        end
      end
    end else begin
      case (c)
        1: begin e_tag = "R3"; e_ack = 1; m_wel = 1; end
        2: begin e_tag = "R3"; e_ack = 1; m_wel = 0; end
        3, 4, 5: begin e_tag = "R10"; e_ack = 1; end
        6: begin
          e_tag = "R4";
          if (m_wel && !is_prot(m_bp, a)) begin
            e_ack = 1; e_start = 1; e_op = 0; m_op = 0; m_wip = 1; m_left = NT;
          end else e_nack = 1;
        end
        7: begin
          e_tag = "R5";
          if (m_wel) begin
            e_ack = 1; e_start = 1; e_op = 1; m_op = 1; m_wip = 1; m_left = NT;
            m_pend = d[4:3];
          end else e_nack = 1;
        end
        8, 9: begin
          e_tag = "R6";
          if (m_wel && m_bp == 2'b00) begin
            e_ack = 1; e_start = 1; e_op = (c == 8) ? 2'd2 : 2'd3;
            m_op = e_op; m_wip = 1; m_left = LT;
          end else e_nack = 1;
        end
        default: ;
      endcase
    end
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 1'b1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_wel = 0; m_wip = 0; m_bp = 0; m_pend = 0; m_op = 0; m_left = 0;
    e_ack = 0; e_nack = 0; e_start = 0; e_done = 0; e_op = 0; e_tag = "R2";
    repeat (3) @(negedge clk);
    // R2: reset values
    chk("R2 status", status, 8'h00);
    chk("R2 ack", ack, 1'b0);
    chk("R2 wr_start", wr_start, 1'b0);
    rst_n = 1'b1;
    // R5: status write without latch
    cyc(7, 0, 8'h18, 0);
    // R3: enable, disable, enable
    cyc(1, 0, 0, 0); cyc(2, 0, 0, 0); cyc(1, 0, 0, 0);
    // R5 accepted, R8 status write lands protect 01
    cyc(7, 0, 8'h08, 0);
    run_ticks(NT + 2);
    // R4: protect 01, top quarter blocked, latch kept
    cyc(1, 0, 0, 0);
    cyc(6, DEPTH - 1, 0, 0);
    cyc(6, (3 * DEPTH) / 4, 0, 0);
    cyc(6, (3 * DEPTH) / 4 - 1, 0, 0);
    run_ticks(NT + 1);
    // R6: fill blocked while protect nonzero
    cyc(1, 0, 0, 0);
    cyc(8, 0, 0, 0);
    cyc(9, 0, 0, 0);
    // protect 10 then 11
    cyc(7, 0, 8'h10, 0); run_ticks(NT + 1);
    cyc(1, 0, 0, 0); cyc(6, DEPTH / 2, 0, 0); cyc(6, DEPTH / 2 - 1, 0, 0);
    run_ticks(NT + 1);
    cyc(1, 0, 0, 0); cyc(7, 0, 8'h18, 0); run_ticks(NT + 1);
    cyc(1, 0, 0, 0); cyc(6, 0, 0, 0);
    cyc(7, 0, 8'h00, 0); run_ticks(NT + 1);
    // R6 accepted, R9 commands during long cycle
    cyc(1, 0, 0, 0); cyc(9, 0, 0, 0);
    cyc(3, 0, 0, 1); cyc(4, 0, 0, 0); cyc(1, 0, 0, 1); cyc(6, 0, 0, 0);
    run_ticks(LT);
    cyc(1, 0, 0, 0); cyc(8, 0, 0, 0); run_ticks(LT + 1);
    // R10 idle reads
    cyc(3, 0, 0, 0); cyc(4, 0, 0, 0); cyc(5, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r, c;
      r = $urandom % 100;
      if (r < 30)      c = 0;
      else if (r < 50) c = 1;
      else if (r < 53) c = 2;
      else             c = 3 + ($urandom % 7);
      cyc(c, $urandom % DEPTH, 8'($urandom), 1'($urandom % 2));
    end
    cyc(0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule